// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This unit turns the indexed-mode postbyte of a small 8/16-bit processor into a 16-bit effective address. The instruction sequencer offers a postbyte on a valid/ready port. It also supplies the live values of the four base registers (X, Y, SP, PC) and of the two 8-bit accumulators, whose concatenation forms the 16-bit D accumulator. When the chosen format carries more offset bits, the unit pulls one or two extension bytes from a byte-serial valid/ready stream.

For the two pointer-chasing formats, the unit issues a 16-bit read request and waits for the returned word. That word becomes the effective address.

The result is reported with a one-cycle done strobe. In the auto-modify formats, the same strobe carries a write-back of the updated base register, which the register file applies. The unit accepts the next postbyte only while it is idle.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset the unit is idle: `pb_ready`=1, `ext_ready`=0, `rd_req`=0, `done`=0, `wb_valid`=0.
- R2: The base select `rr` encodes 00=X, 01=Y, 10=SP, 11=PC. It is taken from postbyte bits 7:6, except when bits 7:5 are 111, in which case it is taken from bits 4:3. Postbyte `rr0nnnnn` gives EA = base + sign-extended `nnnnn`, with no extension byte fetched.
- R3: Postbyte `rr1pnnnn` with `rr` not 11 is auto-modify. A 4-bit `nnnn` of 0..7 means +1..+8, and 8..15 means -8..-1. The updated value is base+amount modulo 2^16. With `p`=0 (pre) EA is the updated value. With `p`=1 (post) EA is the original base. In both cases `wb_valid`=1, `wb_sel`=`rr` and `wb_value`=updated value, all together with `done`. The PC is never written back.
- R4: Postbyte `111rr00s` fetches one extension byte. EA = base + the 9-bit signed offset `{s, byte}`.
- R5: Postbyte `111rr010` fetches two extension bytes, high byte first. EA = base + `{hi, lo}` modulo 2^16.
- R6: Postbyte `111rr1aa` with `aa` of 00, 01 or 10 adds, respectively, A zero-extended, B zero-extended, or D = `{A, B}` to the base. No extension byte is fetched.
- R7: Postbyte `111rr011` (after its two extension bytes) and postbyte `111rr111` (at once, offset D) raise `rd_req` with `rd_addr` = base + offset. Both are held steady until `rd_resp_valid`. EA is then `rd_resp_data`.
- R8: `done` is a single-cycle pulse in the cycle after the last postbyte or extension-byte handshake, or after the read response. `wb_valid` is 0 in all formats that are not auto-modify.
- R9: While a fetch or read is in progress, `pb_ready`=0 and an offered postbyte has no effect. While the unit is idle, `ext_ready`=0 and extension bytes are not consumed.
- R10: The base register and accumulator values are sampled when the postbyte is accepted. Changes to them during extension fetch do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_valid | input | 1 | Postbyte offered |
| pb_data | input | 8 | Postbyte |
| pb_ready | output | 1 | Unit idle, postbyte accepted |
| ext_valid | input | 1 | Extension byte offered |
| ext_data | input | 8 | Extension byte |
| ext_ready | output | 1 | Unit waiting for an extension byte |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_resp_valid | input | 1 | Pointer read response valid |
| rd_resp_data | input | 16 | Returned pointer |
| ea | output | 16 | Effective address, valid with done |
| done | output | 1 | Result strobe |
| wb_valid | output | 1 | Base register write-back valid |
| wb_sel | output | 2 | Register to write back (rr encoding) |
| wb_value | output | 16 | Updated register value |

## Verification
The assertions assume that the read port answers only a request that is pending. They also assume that a response, once it arrives, is taken in that same cycle, so that nothing outside the handshakes can cause a done strobe.

The stimulus keeps within these assumptions. It raises `rd_resp_valid` only while `rd_req` is observed high, after a variable wait, and drops each valid one cycle after its handshake. The only deliberate breach is a postbyte or extension byte offered while the unit cannot take it, and that breach is exactly what R9 says must be ignored.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
    localparam int DW  = 8;
    localparam int AW  = 2 * DW;
    localparam int RSW = 2;

    typedef enum logic [2:0] {
        AM_OFF5, AM_AUTO, AM_OFF9, AM_OFF16, AM_IND16, AM_ACC, AM_INDD
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_EXT_HI, ST_EXT_LO, ST_READ
    } state_e;

    typedef struct packed {
        amode_e           mode;
        logic [RSW-1:0]   base_sel;
        logic [AW-1:0]    imm;
        logic             pre;
    } pb_dec_t;

    typedef struct packed {
        state_e           state;
        logic             ind;
        logic [AW-1:0]    base;
        logic [DW-1:0]    hi;
        logic [AW-1:0]    rd_addr;
        logic [AW-1:0]    ea;
        logic             done;
        logic             wb_valid;
        logic [RSW-1:0]   wb_sel;
        logic [AW-1:0]    wb_value;
    } ea_regs_t;
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [DW-1:0] pb,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    output pb_dec_t       dec
);
    amode_e         mode_w;
    logic [RSW-1:0] sel_w;
    logic [AW-1:0]  imm_w;
    logic           pre_w;

    always_comb begin
        mode_w = AM_OFF5;
        sel_w  = pb[7:6];
        imm_w  = '0;
        pre_w  = 1'b0;
        if (pb[7:5] == 3'b111) begin
            sel_w = pb[4:3];
            if (pb[2]) begin
                case (pb[1:0])
                    2'b00:   begin mode_w = AM_ACC;  imm_w = {{DW{1'b0}}, acc_a}; end
                    2'b01:   begin mode_w = AM_ACC;  imm_w = {{DW{1'b0}}, acc_b}; end
                    2'b10:   begin mode_w = AM_ACC;  imm_w = {acc_a, acc_b}; end
                    default: begin mode_w = AM_INDD; imm_w = {acc_a, acc_b}; end
                endcase
            end else if (pb[1]) begin
                mode_w = pb[0] ? AM_IND16 : AM_OFF16;
            end else begin
                mode_w = AM_OFF9;
                imm_w  = {{DW{pb[0]}}, {DW{1'b0}}};
            end
        end else if (!pb[5]) begin
            mode_w = AM_OFF5;
            imm_w  = {{(AW-5){pb[4]}}, pb[4:0]};
        end else begin
            mode_w = AM_AUTO;
            pre_w  = !pb[4];
            imm_w  = pb[3] ? {{(AW-4){1'b1}}, pb[3:0]}
                           : AW'(pb[3:0]) + AW'(1);
        end
    end

    assign dec = '{mode: mode_w, base_sel: sel_w, imm: imm_w, pre: pre_w};
endmodule

// File: rtl/idx_ea_add.sv
module idx_ea_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    assign sum = a + b;
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
    import idx_ea_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pb_valid,
    input  logic [DW-1:0]  pb_data,
    output logic           pb_ready,
    input  logic           ext_valid,
    input  logic [DW-1:0]  ext_data,
    output logic           ext_ready,
    input  logic [AW-1:0]  reg_x,
    input  logic [AW-1:0]  reg_y,
    input  logic [AW-1:0]  reg_sp,
    input  logic [AW-1:0]  reg_pc,
    input  logic [DW-1:0]  acc_a,
    input  logic [DW-1:0]  acc_b,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_resp_valid,
    input  logic [AW-1:0]  rd_resp_data,
    output logic [AW-1:0]  ea,
    output logic           done,
    output logic           wb_valid,
    output logic [RSW-1:0] wb_sel,
    output logic [AW-1:0]  wb_value
);
    ea_regs_t      q, d;
    pb_dec_t       dec;
    logic [AW-1:0] base_mux;
    logic [AW-1:0] sum_now;
    logic [AW-1:0] sum_ext;

    idx_ea_decode u_dec (
        .pb    (pb_data),
        .acc_a (acc_a),
        .acc_b (acc_b),
        .dec   (dec)
    );

    always_comb begin
        case (dec.base_sel)
            2'b00:   base_mux = reg_x;
            2'b01:   base_mux = reg_y;
            2'b10:   base_mux = reg_sp;
            default: base_mux = reg_pc;
        endcase
    end

    idx_ea_add #(.W(AW)) u_add_now (
        .a   (base_mux),
        .b   (dec.imm),
        .sum (sum_now)
    );

    idx_ea_add #(.W(AW)) u_add_ext (
        .a   (q.base),
        .b   ({q.hi, ext_data}),
        .sum (sum_ext)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.wb_valid = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (pb_valid) begin
                    d.base = base_mux;
                    d.hi   = dec.imm[AW-1:DW];
                    d.ind  = (dec.mode == AM_IND16);
                    case (dec.mode)
                        AM_OFF5, AM_ACC: begin
                            d.ea   = sum_now;
                            d.done = 1'b1;
                        end
                        AM_AUTO: begin
                            d.ea       = dec.pre ? sum_now : base_mux;
                            d.wb_valid = 1'b1;
                            d.wb_sel   = dec.base_sel;
                            d.wb_value = sum_now;
                            d.done     = 1'b1;
                        end
                        AM_OFF9:           d.state = ST_EXT_LO;
                        AM_OFF16, AM_IND16: d.state = ST_EXT_HI;
                        default: begin
                            d.rd_addr = sum_now;
                            d.state   = ST_READ;
                        end
                    endcase
                end
            end
            ST_EXT_HI: begin
                if (ext_valid) begin
                    d.hi    = ext_data;
                    d.state = ST_EXT_LO;
                end
            end
            ST_EXT_LO: begin
                if (ext_valid) begin
                    if (q.ind) begin
                        d.rd_addr = sum_ext;
                        d.state   = ST_READ;
                    end else begin
                        d.ea    = sum_ext;
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            default: begin
                if (rd_resp_valid) begin
                    d.ea    = rd_resp_data;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign pb_ready  = (q.state == ST_IDLE);
    assign ext_ready = (q.state == ST_EXT_HI) || (q.state == ST_EXT_LO);
    assign rd_req    = (q.state == ST_READ);
    assign rd_addr   = q.rd_addr;
    assign ea        = q.ea;
    assign done      = q.done;
    assign wb_valid  = q.wb_valid;
    assign wb_sel    = q.wb_sel;
    assign wb_value  = q.wb_value;

    assert_wb_not_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (done && wb_sel != 2'b11));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_resp_valid) |=> (rd_req && $stable(rd_addr)));

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past((pb_valid && pb_ready) || (ext_valid && ext_ready)
                       || (rd_req && rd_resp_valid)));

    assert_busy_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pb_ready) |-> $past(pb_valid));

    assert_ext_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ready) |-> $past(pb_valid && pb_ready));
endmodule

// File: tb/sim_idx_ea_unit.sv
`timescale 1ns/1ps
module sim_idx_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pb_valid = 1'b0;
    logic [7:0]  pb_data = 8'h00;
    logic        pb_ready;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_data = 8'h00;
    logic        ext_ready;
    logic [15:0] reg_x = 16'h0, reg_y = 16'h0, reg_sp = 16'h0, reg_pc = 16'h0;
    logic [7:0]  acc_a = 8'h0, acc_b = 8'h0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_resp_valid = 1'b0;
    logic [15:0] rd_resp_data = 16'h0;
    logic [15:0] ea;
    logic        done;
    logic        wb_valid;
    logic [1:0]  wb_sel;
    logic [15:0] wb_value;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    idx_ea_unit u0 (
        .clk(clk), .rst_n(rst_n), .pb_valid(pb_valid), .pb_data(pb_data),
        .pb_ready(pb_ready), .ext_valid(ext_valid), .ext_data(ext_data),
        .ext_ready(ext_ready), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
        .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .ea(ea), .done(done), .wb_valid(wb_valid),
        .wb_sel(wb_sel), .wb_value(wb_value)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Issue one postbyte with its extension bytes and check the result.
    task automatic run_op(input logic [7:0] pb, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [15:0] rdat, input int rdelay);
        int rr, base, off, nb, amt, upd, exp_ea, x_ea;
        bit ind, auto_m;
        string tag;
        rr = (pb[7:5] == 3'b111) ? int'(pb[4:3]) : int'(pb[7:6]);
        base = (rr == 0) ? int'(reg_x) : (rr == 1) ? int'(reg_y) :
               (rr == 2) ? int'(reg_sp) : int'(reg_pc);
        nb = 0; ind = 0; auto_m = 0; off = 0; upd = 0;
        if (pb[7:5] != 3'b111 && !pb[5]) begin
            tag = "R2";
            off = (int'(pb[4:0]) >= 16) ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
            exp_ea = (base + off) & 16'hFFFF;
        end else if (pb[7:5] != 3'b111) begin
            tag = "R3"; auto_m = 1;
            amt = (int'(pb[3:0]) < 8) ? int'(pb[3:0]) + 1 : int'(pb[3:0]) - 16;
            upd = (base + amt) & 16'hFFFF;
            exp_ea = pb[4] ? base : upd;
        end else if (!pb[2]) begin
            if (!pb[1]) begin
                tag = "R4"; nb = 1;
                off = pb[0] ? int'(lo) - 256 : int'(lo);
            end else begin
                nb = 2; ind = pb[0];
                tag = ind ? "R7" : "R5";
                off = int'(hi) * 256 + int'(lo);
            end
            exp_ea = (base + off) & 16'hFFFF;
        end else begin
            case (pb[1:0])
                2'b00: off = int'(acc_a);
                2'b01: off = int'(acc_b);
                default: off = int'(acc_a) * 256 + int'(acc_b);
            endcase
            ind = (pb[1:0] == 2'b11);
            tag = ind ? "R7" : "R6";
            exp_ea = (base + off) & 16'hFFFF;
        end

        @(negedge clk);
        chk("R1", "pb_ready idle", int'(pb_ready), 1);
        pb_valid = 1'b1; pb_data = pb;
        @(negedge clk);
        pb_valid = 1'b0;
        for (int k = 0; k < nb; k++) begin
            chk(tag, "ext_ready", int'(ext_ready), 1);
            ext_valid = 1'b1;
            ext_data  = (nb == 2 && k == 0) ? hi : lo;
            @(negedge clk);
            ext_valid = 1'b0;
        end
        x_ea = exp_ea;
        if (ind) begin
            chk("R7", "rd_req", int'(rd_req), 1);
            chk("R7", "rd_addr", int'(rd_addr), exp_ea);
            chk("R8", "no early done", int'(done), 0);
            for (int w = 0; w < rdelay; w++) begin
                @(negedge clk);
                chk("R7", "rd_req held", int'(rd_req), 1);
            end
            rd_resp_valid = 1'b1; rd_resp_data = rdat;
            @(negedge clk);
            rd_resp_valid = 1'b0;
            x_ea = int'(rdat);
        end
        chk("R8", "done", int'(done), 1);
        chk(tag, "ea", int'(ea), x_ea);
        chk(auto_m ? "R3" : "R8", "wb_valid", int'(wb_valid), int'(auto_m));
        if (auto_m) begin
            chk("R3", "wb_sel", int'(wb_sel), rr);
            chk("R3", "wb_value", int'(wb_value), upd);
        end
        @(negedge clk);
        chk("R8", "done pulse ends", int'(done), 0);
    endtask

    task automatic set_regs(input int s);
        case (s)
            0: begin reg_x = 16'h1234; reg_y = 16'h8000; reg_sp = 16'h0FFE;
                     reg_pc = 16'hC000; acc_a = 8'h12; acc_b = 8'hF0; end
            1: begin reg_x = 16'h0000; reg_y = 16'hFFFF; reg_sp = 16'h0003;
                     reg_pc = 16'h7FF8; acc_a = 8'hFF; acc_b = 8'h80; end
            default: begin reg_x = 16'hFFF8; reg_y = 16'h0007; reg_sp = 16'h8001;
                     reg_pc = 16'hFFFF; acc_a = 8'h00; acc_b = 8'h01; end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset pb_ready", int'(pb_ready), 1);
        chk("R1", "reset ext_ready", int'(ext_ready), 0);
        chk("R1", "reset rd_req", int'(rd_req), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset wb_valid", int'(wb_valid), 0);
        rst_n = 1'b1;

        // full postbyte sweep over three register sets
        for (int s = 0; s < 3; s++) begin
            set_regs(s);
            for (int p = 0; p < 256; p++) begin
                run_op(8'(p), 8'(p * 7 + s * 91), 8'(p * 13 + 5 + s * 37),
                       16'(p * 257 + s * 4099), p % 3);
            end
        end

        // R9: extension byte offered while idle is not consumed
        set_regs(0);
        @(negedge clk);
        ext_valid = 1'b1; ext_data = 8'hAA;
        @(negedge clk);
        chk("R9", "ext_ready idle", int'(ext_ready), 0);
        chk("R9", "no done from idle ext", int'(done), 0);
        ext_valid = 1'b0;
        run_op(8'hE0, 8'h00, 8'h05, 16'h0, 0);

        // R9: postbyte offered while busy is ignored
        @(negedge clk);
        pb_valid = 1'b1; pb_data = 8'hE2;
        @(negedge clk);
        chk("R9", "pb_ready busy", int'(pb_ready), 0);
        pb_data = 8'h00;
        ext_valid = 1'b1; ext_data = 8'h01;
        @(negedge clk);
        pb_valid = 1'b0;
        ext_data = 8'h10;
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R9", "ea busy pb ignored", int'(ea), (16'h1234 + 16'h0110) & 16'hFFFF);
        @(negedge clk);
        chk("R9", "stray pb not accepted", int'(done), 0);
        chk("R9", "idle after stray", int'(pb_ready), 1);

        // R10: base sampled at postbyte acceptance
        @(negedge clk);
        pb_valid = 1'b1; pb_data = 8'hE2;
        @(negedge clk);
        pb_valid = 1'b0;
        reg_x = 16'h5555;
        ext_valid = 1'b1; ext_data = 8'h00;
        @(negedge clk);
        ext_data = 8'h20;
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R10", "base snapshot", int'(ea), 16'h1254);

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule